// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. Each bus cycle carries a word index, a write strobe and write data, and read data comes back one cycle later. Software programs a 16-bit compare value, picks one of three count sources and a power-of-four prescale, then enables counting. From then on it must keep clearing the counter. If it stops doing so, the counter reaches the compare value and the block raises a one-cycle reset request.

The three count sources arrive as single-cycle tick pulses that are already in the system clock domain. Bit 0 of the source tick input is the peripheral-clock source, bit 1 the real-time-clock source and bit 2 the external source. The selected ticks pass through a divider of 1, 4, 16, 64, 256 or 1024. Each divided tick advances the 16-bit up-counter by one.

The usual bring-up sequence has six steps:
1. Disable counting.
2. Write the control register with no source selected.
3. Load the compare value.
4. Clear the counter.
5. Write the control register with the source selected.
6. Enable counting.

Top module: `wdog_prescaled`

## Requirements
- R1: A synchronous active-high reset clears the compare, enable, counter and control registers, the prescaler, the read data output and the reset request.
- R2: Word index 0 (byte offset 0x0) is the 16-bit compare value, index 1 (0x4) is the enable bit in data bit 0, index 2 (0x8) is the counter and index 3 (0xC) is the 6-bit control register. Read data shows the addressed register one cycle after the address is presented, as it stood before any write in that same cycle. Unused upper bits read as zero.
- R3: Control bits 2:0 choose the count source one-hot: bit 0 selects source tick 0, bit 1 selects tick 1 and bit 2 selects tick 2. A control value with no source bit set, or with more than one set, produces no counting.
- R4: Control bits 5:3 hold a prescale code c. Codes 0 to 5 divide the selected ticks by 4^c, and codes 6 and 7 divide by 1024. After the divider is cleared, the first counter increment happens on the 4^c-th selected tick.
- R5: The counter increments by one per divided tick only while the enable bit is 1. After enable is written 0, the counter holds its value.
- R6: When an increment would make the counter (modulo 2^16) equal the compare value, the counter becomes 0 and the reset request is high for exactly that one following cycle. With a compare value of 0, this happens on the 65536th increment.
- R7: A write to the counter loads the written data; writing 0 is the service action. The write takes priority over a divided tick in the same cycle, so that tick neither counts nor raises a reset request.
- R8: A write to the control register, a write of 0 to the enable bit, and a disabled counter each clear the prescaler's divider state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register word index (byte offset divided by 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_tick | input | 3 | Per-source count tick pulses, system clock domain |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench drives each prescale code, including the two codes above 5. A divider with the wrong limit, or one that lets codes 6 and 7 wrap to small divides, shifts the cycle at which the counter read-back first moves. Illegal source selections with every tick line active catch a design that ORs the source bits instead of requiring one-hot. A compare value of 0 forces the full 65536-increment wrap; a design that compares before incrementing would pulse on every tick instead. Service writes that coincide with a divided tick expose a design that lets the tick win. Control rewrites part-way through a divide period expose a prescaler that keeps stale divider state.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Register word indices on the bus
  typedef enum logic [1:0] {
    REG_CMP  = 2'd0,
    REG_EN   = 2'd1,
    REG_CNT  = 2'd2,
    REG_CTRL = 2'd3
  } wdog_reg_e;

  localparam int unsigned NUM_SRC      = 3;
  localparam int unsigned PRE_CODE_W   = 3;
  localparam int unsigned PRE_MAX_CODE = 5;
  localparam int unsigned CTRL_W       = NUM_SRC + PRE_CODE_W;

endpackage

// File: rtl/wdog_src_sel.sv
module wdog_src_sel #(
  parameter int unsigned NSRC = 3
) (
  input  logic [NSRC-1:0] sel,
  input  logic [NSRC-1:0] ticks,
  output logic            tick_out
);

  logic [NSRC-1:0] gated;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_gate
      assign gated[g] = sel[g] & ticks[g];
    end
  endgenerate

  // Only a legal one-hot selection lets a tick through
  assign tick_out = $onehot(sel) & (|gated);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned MAX_CODE = 5,
  localparam int unsigned DIV_W   = (MAX_CODE > 0) ? 2 * MAX_CODE : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick_in,
  input  logic [CODE_W-1:0] code,
  output logic              tick_out
);

  logic [CODE_W-1:0] code_eff;
  logic [DIV_W-1:0]  lim;
  logic [DIV_W-1:0]  div_q;
  logic              at_lim;

  // Codes above the largest supported one saturate to it
  always_comb begin
    code_eff = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
  end

  // Terminal count for divide by 4^code
  always_comb begin
    lim = '0;
    for (int i = 0; i <= int'(MAX_CODE); i++) begin
      if (code_eff == CODE_W'(i)) lim = DIV_W'((64'd1 << (2 * i)) - 64'd1);
    end
  end

  assign at_lim   = (div_q == lim);
  assign tick_out = tick_in & at_lim;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (tick_in) begin
      div_q <= at_lim ? '0 : div_q + 1'b1;
    end
  end

  // R4: the divider never runs past its terminal count
  p_div_bound_r4: assert property (@(posedge clk) disable iff (rst)
    div_q <= lim);

  // R8: a clear request empties the divider on the next cycle
  p_div_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (div_q == '0));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic             hit_q;

  always_comb nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= 1'b0;
      if (wr) begin
        cnt_q <= wdata;
      end else if (en && tick) begin
        if (nxt == cmp) begin
          cnt_q <= '0;
          hit_q <= 1'b1;
        end else begin
          cnt_q <= nxt;
        end
      end
    end
  end

  assign cnt = cnt_q;
  assign hit = hit_q;

  // R5: a disabled counter with no write holds its value
  p_hold_off_r5: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr) |=> $stable(cnt_q));

  // R5: no reset request may follow a disabled cycle
  p_quiet_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> !hit_q);

  // R7: a service write loads the data and suppresses the timeout
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt_q == $past(wdata)) && !hit_q);

  // R6: a timeout always leaves the counter at zero
  p_hit_zero_r6: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> (cnt_q == '0));

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_SRC-1:0]   src_tick,
  output logic                 rst_req
);

  wdog_reg_e         reg_sel;
  logic              we_cmp, we_en, we_cnt, we_ctrl;
  logic [DATA_W-1:0] cmp_q;
  logic              en_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] rdata_q;
  logic              raw_tick, pre_tick, pre_clr, hit;

  assign reg_sel = wdog_reg_e'(bus_addr);
  assign we_cmp  = bus_we && (reg_sel == REG_CMP);
  assign we_en   = bus_we && (reg_sel == REG_EN);
  assign we_cnt  = bus_we && (reg_sel == REG_CNT);
  assign we_ctrl = bus_we && (reg_sel == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      ctrl_q <= '0;
    end else begin
      if (we_cmp)  cmp_q  <= bus_wdata;
      if (we_en)   en_q   <= bus_wdata[0];
      if (we_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  wdog_src_sel #(.NSRC(NUM_SRC)) u_src (
    .sel      (ctrl_q[NUM_SRC-1:0]),
    .ticks    (src_tick),
    .tick_out (raw_tick)
  );

  assign pre_clr = we_ctrl | ~en_q | (we_en & ~bus_wdata[0]);

  wdog_prescaler #(.CODE_W(PRE_CODE_W), .MAX_CODE(PRE_MAX_CODE)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (pre_clr),
    .tick_in  (raw_tick),
    .code     (ctrl_q[CTRL_W-1:NUM_SRC]),
    .tick_out (pre_tick)
  );

  wdog_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (en_q),
    .tick  (pre_tick),
    .wr    (we_cnt),
    .wdata (bus_wdata),
    .cmp   (cmp_q),
    .cnt   (cnt),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (reg_sel)
        REG_CMP:  rdata_q <= cmp_q;
        REG_EN:   rdata_q <= {{(DATA_W-1){1'b0}}, en_q};
        REG_CNT:  rdata_q <= cnt;
        REG_CTRL: rdata_q <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign rst_req   = hit;

  // R3: an illegal source selection never yields a divided tick
  p_no_tick_badsel_r3: assert property (@(posedge clk) disable iff (rst)
    !$onehot(ctrl_q[NUM_SRC-1:0]) |-> !pre_tick);

  // R2: the enable register reads back with its upper bits zero
  p_en_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == REG_EN) |=> (bus_rdata[DATA_W-1:1] == '0));

  // R1: nothing is requested in the cycle right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !rst_req && (bus_rdata == '0));

endmodule

// File: tb/tb_wdog_prescaled.sv
module tb_wdog_prescaled;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  src_tick = '0;
  logic        rst_req;

  always #10 clk = ~clk;

  wdog_prescaled dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .rst_req(rst_req)
  );

  // Behavioural reference state
  int m_cmp = 0, m_en = 0, m_cnt = 0, m_ctrl = 0, m_div = 0;
  int exp_rdata = 0, exp_rst = 0;
  string pend_tag = "R1";
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check();
    n_cmp++;
    if (int'(bus_rdata) != exp_rdata) begin
      n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h", pend_tag, bus_rdata, exp_rdata[15:0]);
    end
    n_cmp++;
    if (int'(rst_req) != exp_rst) begin
      n_bad++;
      $display("FAIL %s rst_req actual=%0d expected=%0d", pend_tag, rst_req, exp_rst);
    end
  endtask

  task automatic model(input int r, input int a, input int w, input int d, input int t);
    int sel, raw, code, lim, ptick, n, hit;
    if (r != 0) begin
      m_cmp = 0; m_en = 0; m_cnt = 0; m_ctrl = 0; m_div = 0;
      exp_rdata = 0; exp_rst = 0;
      return;
    end
    sel  = m_ctrl & 7;
    raw  = ((sel == 1 || sel == 2 || sel == 4) && ((t & sel) != 0)) ? 1 : 0;
    code = m_ctrl >> 3;
    if (code > 5) code = 5;
    lim   = (1 << (2 * code)) - 1;
    ptick = (m_en != 0 && raw != 0 && m_div == lim) ? 1 : 0;
    case (a)
      0: exp_rdata = m_cmp;
      1: exp_rdata = m_en;
      2: exp_rdata = m_cnt;
      default: exp_rdata = m_ctrl;
    endcase
    hit = 0;
    if (w != 0 && a == 2) m_cnt = d;
    else if (ptick != 0) begin
      n = (m_cnt + 1) % 65536;
      if (n == m_cmp) begin m_cnt = 0; hit = 1; end
      else m_cnt = n;
    end
    if ((w != 0 && a == 3) || m_en == 0 || (w != 0 && a == 1 && (d & 1) == 0)) m_div = 0;
    else if (raw != 0) m_div = (m_div == lim) ? 0 : m_div + 1;
    if (w != 0 && a == 0) m_cmp = d;
    if (w != 0 && a == 1) m_en = d & 1;
    if (w != 0 && a == 3) m_ctrl = d & 63;
    exp_rst = hit;
  endtask

  task automatic cyc(input int r, input int a, input int w, input int d, input int t, input string tag);
    @(negedge clk);
    check();
    rst = r[0]; bus_addr = a[1:0]; bus_we = w[0]; bus_wdata = d[15:0]; src_tick = t[2:0];
    model(r, a, w, d, t);
    pend_tag = tag;
  endtask

  task automatic wr(input int a, input int d, input string tag);
    cyc(0, a, 1, d, 0, tag);
  endtask

  task automatic run(input int n, input int t, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 2, 0, 0, t, tag);
  endtask

  task automatic setup(input int ctrl, input int cmpv, input string tag);
    wr(1, 0, tag);
    wr(3, ctrl & 56, tag);
    wr(0, cmpv, tag);
    wr(2, 0, tag);
    wr(3, ctrl, tag);
    wr(1, 1, tag);
  endtask

  initial begin
    // R1: reset state of every register and output
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 7, "R1");
    for (int i = 0; i < 4; i++) cyc(0, i, 0, 0, 7, "R1");

    // R2: register map, read-back widths, read-before-write
    wr(0, 16'hABCD, "R2");  cyc(0, 0, 0, 0, 0, "R2");
    wr(0, 16'h1111, "R2");  cyc(0, 0, 0, 0, 0, "R2");
    wr(1, 16'hFFFE, "R2");  cyc(0, 1, 0, 0, 0, "R2");
    wr(1, 16'h0003, "R2");  cyc(0, 1, 0, 0, 0, "R2");
    wr(1, 0, "R2");
    wr(3, 16'hFFC0, "R2");  cyc(0, 3, 0, 0, 0, "R2");
    wr(3, 16'hFFFF, "R2");  cyc(0, 3, 0, 0, 0, "R2");
    wr(2, 16'h1234, "R2");  cyc(0, 2, 0, 0, 0, "R2");

    // R5: counting only while enabled
    setup(8'h01, 20, "R5");
    run(10, 1, "R5");
    wr(1, 0, "R5");
    run(10, 1, "R5");

    // R3: source selection, illegal selections
    for (int s = 0; s < 3; s++) begin
      setup(1 << s, 1000, "R3");
      run(6, 7 & ~(1 << s), "R3");
      run(6, 1 << s, "R3");
    end
    setup(0, 1000, "R3");  run(8, 7, "R3");
    setup(3, 1000, "R3");  run(8, 7, "R3");
    setup(7, 1000, "R3");  run(8, 7, "R3");
    setup(6, 1000, "R3");  run(8, 7, "R3");

    // R4: every prescale code, including the saturating ones
    for (int c = 0; c < 8; c++) begin
      setup((c << 3) | 2, 0, "R4");
      run(3 * (1 << (2 * ((c > 5) ? 5 : c))) + 5, 2, "R4");
    end

    // R6: timeouts, back-to-back timeouts, full wrap with zero compare
    setup(8'h04, 5, "R6");   run(30, 4, "R6");
    setup(8'h04, 1, "R6");   run(6, 4, "R6");
    setup(8'h04, 0, "R6");   run(65540, 4, "R6");

    // R7: service writes racing divided ticks
    setup(8'h01, 8, "R7");
    for (int k = 0; k < 10; k++) begin
      run(4, 1, "R7");
      cyc(0, 2, 1, 0, 1, "R7");
    end
    cyc(0, 2, 1, 7, 1, "R7");
    run(4, 1, "R7");

    // R8: control rewrite and enable drop restart the divider
    setup(8'h11, 100, "R8");
    run(10, 1, "R8");
    cyc(0, 3, 1, 8'h11, 1, "R8");
    run(20, 1, "R8");
    cyc(0, 1, 1, 0, 1, "R8");
    cyc(0, 1, 1, 1, 1, "R8");
    run(20, 1, "R8");

    // R5: mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int a, w, d;
      a = int'($urandom_range(3, 0));
      w = ($urandom_range(7, 0) == 0) ? 1 : 0;
      d = int'($urandom_range(65535, 0));
      if (a == 3) d = d & 16'h001F;
      if (a == 0) d = d & 16'h003F;
      cyc(0, a, w, d, int'($urandom_range(7, 0)), "R5");
    end

    @(negedge clk);
    check();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule